// File: doc/BRIEF.md
# Quad Continuous-Read Flash Fetch Engine

This block turns single-word read requests from an on-chip bus into reads from a serial NOR flash over four data lines. It keeps the flash in continuous-read mode, so most accesses skip the instruction byte. The first read after reset, or after the mode-exit input, is an entry transaction. It shifts the 8-bit read opcode out on line 0, one bit per serial clock. It then sends the 24-bit address and a mode byte as nibbles on all four lines, runs a programmable number of dummy clocks with the lines released, and collects eight data nibbles. The mode byte tells the flash to stay in continuous mode, so every later read starts directly with the address.

The serial clock runs at the system clock divided by an even divisor. Read data is captured one system cycle after the serial clock's rising edge, which gives the flash's clock-to-output time extra margin. Chip select goes high for at least one serial clock period between accesses. A request is accepted only while the engine is idle, and the word comes back as a one-cycle response pulse.

Top module: `qxip_engine`

## Requirements
- R1: After reset, flashCsN is 1, flashSclk is 0, flashIoOe is 0, reqReady is 1 and rspValid is 0.
- R2: The first read after reset sends opcode 0xEB most significant bit first on flashIoOut[0], one bit per flashSclk rising edge, with flashIoOe = 4'b0001 for those 8 clocks.
- R3: Each read drives 8 nibbles on all four lines with flashIoOe = 4'b1111: the 24-bit address, most significant nibble first, then the mode byte 0xA0, high nibble first.
- R4: After the mode byte there are exactly DUMMY_CLKS rising edges with flashIoOe = 0, then 8 data clocks with flashIoOe = 0. The first received byte lands in rspData[7:0], and so on up to rspData[31:24]. Within each byte the high nibble is received first.
- R5: Once the entry transaction is done, later reads have no opcode phase. The first rising edge already carries the top address nibble, and a read takes 16 + DUMMY_CLKS serial clocks.
- R6: A one-cycle pulse on exitMode while idle makes the next read an entry transaction again, with the 0xEB opcode.
- R7: While flashCsN is low, flashSclk is low for CLK_DIV/2 system cycles and high for CLK_DIV/2 system cycles in each period, starting low.
- R8: Each data nibble is taken from flashIoIn one system cycle after the flashSclk rising edge at which the flash presents it.
- R9: reqReady is high only while flashCsN is high. Between two accesses flashCsN stays high for at least CLK_DIV system cycles.
- R10: Each accepted request produces exactly one single-cycle rspValid pulse carrying its word, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Engine idle and able to accept a request |
| reqAddr | input | 24 | Flash byte address of the word |
| exitMode | input | 1 | Forces the entry transaction on the next read |
| rspValid | output | 1 | One-cycle pulse with returned data |
| rspData | output | 32 | Returned word, first received byte in bits 7:0 |
| flashCsN | output | 1 | Flash chip select, active low |
| flashSclk | output | 1 | Flash serial clock |
| flashIoOut | output | 4 | Values driven on flash data lines |
| flashIoOe | output | 4 | Per-line output enables |
| flashIoIn | input | 4 | Values sampled from flash data lines |

## Verification
The bench builds the engine with CLK_DIV = 4 and DUMMY_CLKS = 6. The divisor of 4 separates the serial clock's rising edge, the delayed capture cycle and the end of the period into different system cycles. A flash model that changes its data just after each rising edge therefore catches a capture made at the nominal edge instead of one cycle later. The non-default dummy count checks that the wait phase follows the parameter, and it also moves the data phase away from where the default would put it.

// File: rtl/qxip_pkg.sv
package qxip_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_GAP
  } phase_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;       // latch opcode and address/mode word
    logic shiftCmd;   // advance serial opcode by one bit
    logic shiftAddr;  // advance address/mode word by one nibble
    logic capture;    // take one nibble from the data lines
    logic finish;     // last nibble: publish the word
  } strobe_t;

endpackage

// File: rtl/qxip_ctrl.sv
module qxip_ctrl
  import qxip_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int DUMMY_CLKS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    exitMode,
  output logic    reqReady,
  output phase_t  phase,
  output strobe_t strobe,
  output logic    csN,
  output logic    sclk
);

  localparam int HALF       = CLK_DIV / 2;
  localparam int DIV_W      = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int MAX_BEATS  = (DUMMY_CLKS > 8) ? DUMMY_CLKS : 8;
  localparam int CNT_W      = $clog2(MAX_BEATS + 1);
  localparam int DUMMY_LAST = (DUMMY_CLKS > 0) ? DUMMY_CLKS - 1 : 0;
  localparam phase_t AFTER_ADDR = (DUMMY_CLKS > 0) ? PH_DUMMY : PH_DATA;

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] beatCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             needEntry;
  logic             accept;
  logic             beatEnd;
  logic             midBeat;
  phase_t           nextPhase;

  assign reqReady = (phase == PH_IDLE);
  assign accept   = reqReady && reqValid;
  assign beatEnd  = (divCnt == DIV_W'(CLK_DIV - 1));
  assign midBeat  = (divCnt == DIV_W'(HALF));
  assign csN      = (phase == PH_IDLE) || (phase == PH_GAP);
  assign sclk     = !csN && (divCnt >= DIV_W'(HALF));

  always_comb begin
    case (phase)
      PH_DUMMY: lastIdx = CNT_W'(DUMMY_LAST);
      PH_GAP:   lastIdx = '0;
      default:  lastIdx = CNT_W'(7);
    endcase
    case (phase)
      PH_CMD:   nextPhase = PH_ADDR;
      PH_ADDR:  nextPhase = AFTER_ADDR;
      PH_DUMMY: nextPhase = PH_DATA;
      PH_DATA:  nextPhase = PH_GAP;
      default:  nextPhase = PH_IDLE;
    endcase
  end

  always_comb begin
    strobe.load      = accept;
    strobe.shiftCmd  = (phase == PH_CMD) && beatEnd;
    strobe.shiftAddr = (phase == PH_ADDR) && beatEnd;
    strobe.capture   = (phase == PH_DATA) && midBeat;
    strobe.finish    = (phase == PH_DATA) && midBeat && (beatCnt == CNT_W'(7));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      divCnt    <= '0;
      beatCnt   <= '0;
      needEntry <= 1'b1;
    end else begin
      needEntry <= accept ? 1'b0 : (needEntry | exitMode);
      if (phase == PH_IDLE) begin
        divCnt  <= '0;
        beatCnt <= '0;
        if (accept) phase <= (needEntry || exitMode) ? PH_CMD : PH_ADDR;
      end else begin
        divCnt <= beatEnd ? '0 : divCnt + 1'b1;
        if (beatEnd) begin
          if (beatCnt == lastIdx) begin
            beatCnt <= '0;
            phase   <= nextPhase;
          end else begin
            beatCnt <= beatCnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/qxip_datapath.sv
module qxip_datapath
  import qxip_pkg::*;
#(
  parameter logic [7:0] READ_CMD  = 8'hEB,
  parameter logic [7:0] MODE_BITS = 8'hA0
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strobe,
  input  phase_t      phase,
  input  logic [23:0] reqAddr,
  input  logic [3:0]  ioIn,
  output logic [3:0]  ioOut,
  output logic [3:0]  ioOe,
  output logic        rspValid,
  output logic [31:0] rspData
);

  logic [7:0]  cmdShift;
  logic [31:0] addrShift;
  logic [31:0] gather;
  logic [31:0] fullWord;
  logic [31:0] swapped;

  assign fullWord = {gather[27:0], ioIn};

  // first received byte goes to the least significant lane
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign swapped[g*8 +: 8] = fullWord[(3-g)*8 +: 8];
  end

  always_comb begin
    case (phase)
      PH_CMD: begin
        ioOut = {3'b000, cmdShift[7]};
        ioOe  = 4'b0001;
      end
      PH_ADDR: begin
        ioOut = addrShift[31:28];
        ioOe  = 4'b1111;
      end
      default: begin
        ioOut = 4'b0000;
        ioOe  = 4'b0000;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift  <= '0;
      addrShift <= '0;
      gather    <= '0;
      rspValid  <= 1'b0;
      rspData   <= '0;
    end else begin
      rspValid <= strobe.finish;
      if (strobe.load) begin
        cmdShift  <= READ_CMD;
        addrShift <= {reqAddr, MODE_BITS};
      end else begin
        if (strobe.shiftCmd)  cmdShift  <= {cmdShift[6:0], 1'b0};
        if (strobe.shiftAddr) addrShift <= {addrShift[27:0], 4'b0000};
      end
      if (strobe.capture) gather <= fullWord;
      if (strobe.finish)  rspData <= swapped;
    end
  end

endmodule

// File: rtl/qxip_engine.sv
module qxip_engine
  import qxip_pkg::*;
#(
  parameter int         CLK_DIV    = 2,
  parameter int         DUMMY_CLKS = 4,
  parameter logic [7:0] READ_CMD   = 8'hEB,
  parameter logic [7:0] MODE_BITS  = 8'hA0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [23:0] reqAddr,
  input  logic        exitMode,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        flashCsN,
  output logic        flashSclk,
  output logic [3:0]  flashIoOut,
  output logic [3:0]  flashIoOe,
  input  logic [3:0]  flashIoIn
);

  if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_badDiv
    $error("CLK_DIV must be even and at least 2");
  end

  phase_t  phase;
  strobe_t strobe;

  qxip_ctrl #(
    .CLK_DIV   (CLK_DIV),
    .DUMMY_CLKS(DUMMY_CLKS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .exitMode(exitMode),
    .reqReady(reqReady),
    .phase   (phase),
    .strobe  (strobe),
    .csN     (flashCsN),
    .sclk    (flashSclk)
  );

  qxip_datapath #(
    .READ_CMD (READ_CMD),
    .MODE_BITS(MODE_BITS)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .phase   (phase),
    .reqAddr (reqAddr),
    .ioIn    (flashIoIn),
    .ioOut   (flashIoOut),
    .ioOe    (flashIoOe),
    .rspValid(rspValid),
    .rspData (rspData)
  );

endmodule

// File: rtl/qxip_checker.sv
module qxip_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       rspValid,
  input logic       flashCsN,
  input logic       flashSclk,
  input logic [3:0] flashIoOe
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    flashCsN |-> (!flashSclk && flashIoOe == 4'b0000)); // R1

  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> flashCsN); // R9

  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !flashCsN); // R9

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashCsN) |=> flashCsN); // R9

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R10

  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (flashIoOe == 4'b0000 || flashIoOe == 4'b0001 || flashIoOe == 4'b1111)); // R3

endmodule

bind qxip_engine qxip_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .flashCsN (flashCsN),
  .flashSclk(flashSclk),
  .flashIoOe(flashIoOe)
);

// File: tb/tb_qxip_engine.sv
`timescale 1ns/1ps
module tb_qxip_engine;

  localparam int DIV  = 4;
  localparam int DUM  = 6;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic        exitMode = 1'b0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        flashCsN;
  logic        flashSclk;
  logic [3:0]  flashIoOut;
  logic [3:0]  flashIoOe;
  logic [3:0]  flashIoIn = 4'h0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit needCmd = 1'b1;

  logic [31:0] expQ[$];
  logic [23:0] addrQ[$];

  int sclkErr = 0;
  int sclkEdges = 0;
  int minGap = 1000000;
  int gapsSeen = 0;

  always #2 clk = ~clk;

  qxip_engine #(.CLK_DIV(DIV), .DUMMY_CLKS(DUM)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .exitMode(exitMode), .rspValid(rspValid),
    .rspData(rspData), .flashCsN(flashCsN), .flashSclk(flashSclk),
    .flashIoOut(flashIoOut), .flashIoOe(flashIoOe), .flashIoIn(flashIoIn)
  );

  function automatic logic [31:0] memWord(input logic [23:0] a);
    return ({a[7:0], a} * 32'h0001_0003) ^ 32'hC3A5_5A3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: pushes expectations, then offers the request
  task automatic doRead(input logic [23:0] a);
    @(negedge clk);
    reqAddr  = a;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    expQ.push_back(memWord(a));
    addrQ.push_back(a);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (expQ.size() != 0 || !reqReady) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseExit();
    waitIdle();
    exitMode = 1'b1;
    @(negedge clk);
    exitMode = 1'b0;
    needCmd = 1'b1;
  endtask

  task automatic checkReset();
    @(negedge clk);
    check(flashCsN == 1'b1 && flashSclk == 1'b0 && flashIoOe == 4'h0,
          "R1", "pins after reset", {flashCsN, flashSclk, flashIoOe}, 32'h20);
    check(reqReady == 1'b1 && rspValid == 1'b0, "R1", "handshake after reset",
          {reqReady, rspValid}, 32'h2);
  endtask

  // monitor / scoreboard: R10, R4, R8
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "response with no request", rspData, 32'h0);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(rspData == e, "R4", "R8 returned word", rspData, e);
      end
    end
  end

  // serial clock shape R7 and chip-select gap R9
  always @(negedge clk) begin : shapeMon
    static bit prevS = 1'b0;
    static int run = 0;
    static int gap = 0;
    static bit seenLow = 1'b0;
    if (!rstN) begin
      prevS = 1'b0; run = 0; gap = 0; seenLow = 1'b0;
    end else if (flashCsN) begin
      gap++;
      if (flashSclk) sclkErr++;
      prevS = 1'b0; run = 0;
    end else begin
      if (seenLow == 1'b0 || gap != 0) begin
        if (seenLow && gap != 0) begin
          gapsSeen++;
          if (gap < minGap) minGap = gap;
        end
        seenLow = 1'b1;
        gap = 0;
      end
      if (flashSclk != prevS) begin
        if (run != HALF) sclkErr++;
        sclkEdges++;
        run = 1;
      end else begin
        run++;
      end
      prevS = flashSclk;
    end
  end

  // flash model: decodes the wire, serves data just after each rising edge
  initial begin : flashModel
    forever begin
      bit          hasCmd;
      int          rises;
      int          oeErr;
      int          expRises;
      logic [7:0]  cmdGot;
      logic [31:0] amGot;
      @(negedge flashCsN);
      hasCmd = needCmd;
      needCmd = 1'b0;
      rises = 0; oeErr = 0; cmdGot = '0; amGot = '0;
      expRises = (hasCmd ? 8 : 0) + 16 + DUM;
      while (1) begin
        @(posedge flashSclk or posedge flashCsN);
        if (flashCsN) break;
        if (hasCmd && rises < 8) begin
          if (flashIoOe != 4'b0001) oeErr++;
          cmdGot = {cmdGot[6:0], flashIoOut[0]};
        end else begin
          int j;
          j = rises - (hasCmd ? 8 : 0);
          if (j < 8) begin
            if (flashIoOe != 4'b1111) oeErr++;
            amGot = {amGot[27:0], flashIoOut};
          end else if (j < 8 + DUM) begin
            if (flashIoOe != 4'b0000) oeErr++;
          end else begin
            int k;
            int sh;
            logic [31:0] w;
            if (flashIoOe != 4'b0000) oeErr++;
            k  = j - 8 - DUM;
            sh = 8 * (k / 2) + ((k % 2 == 0) ? 4 : 0);
            w  = memWord(amGot[31:8]);
            #1 flashIoIn = w[sh +: 4];
          end
        end
        rises++;
      end
      check(rises == expRises, hasCmd ? "R2" : "R5", "serial clocks per read",
            rises, expRises);
      if (hasCmd)
        check(cmdGot == 8'hEB, "R2", "opcode bits", cmdGot, 32'hEB);
      check(oeErr == 0, "R3", "R4 enable pattern errors", oeErr, 0);
      check(amGot[7:0] == 8'hA0, "R3", "mode byte", amGot[7:0], 32'hA0);
      if (addrQ.size() != 0) begin
        logic [23:0] ea;
        ea = addrQ.pop_front();
        check(amGot[31:8] == ea, "R3", "address nibbles", amGot[31:8], ea);
      end else begin
        check(1'b0, "R3", "transaction with no request", amGot, 0);
      end
    end
  end

  task automatic finishUp();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkReset();                          // R1

    doRead(24'h000000);                    // R2 entry transaction
    doRead(24'hFFFFFF);                    // R5 address-first
    doRead(24'h123456);                    // R5, back to back
    doRead(24'hA5A5A5);
    waitIdle();

    pulseExit();                           // R6
    doRead(24'h5A5A5A);
    doRead(24'h800001);
    waitIdle();

    @(negedge clk);                        // reset while idle: R1, R2
    rstN = 1'b0;
    needCmd = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    checkReset();
    doRead(24'h0F0F0F);
    doRead(24'h00FF00);
    waitIdle();

    pulseExit();                           // R6 again
    doRead(24'h7E8001);
    waitIdle();

    check(sclkErr == 0 && sclkEdges > 0, "R7", "half-period errors", sclkErr, 0);
    check(gapsSeen > 0 && minGap >= DIV, "R9", "minimum deselect gap", minGap, DIV);
    check(expQ.size() == 0, "R10", "unanswered requests", expQ.size(), 0);
    finishUp();
  end

endmodule